// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block owns the processor status bits and the saved program counters involved in taking a trap and in returning from one. When the core raises a break request, a program exception, a software trap or an external interrupt, the controller saves the return address and the mode bits, switches to supervisor mode with traps disabled, records the handler type and redirects fetch to the handler. The handler address is formed from a vector base and that type. A return-from-trap request takes either the normal return path or the debug return path, or falls to one of the checks for illegal status combinations.

Break entry has its own storage: a debug return address and a saved copy of the supervisor and trap-enable bits. A debug-mode flag then records that the core is inside a break handler. Software trap requests carry a base and an offset, and the block forms the trap number from them. Some status combinations stop the core. When that happens the block raises a sticky halted flag and ignores every later request until reset. A status write port lets the core load the mode bits directly.

All outputs are registered. Every update, including the fetch redirect, takes effect on the clock edge that accepts the request. At most one request is accepted per cycle.

Top module: `trapctl_top`

## Requirements
- R1: After reset: supervisor=1, trap enable=0, previous supervisor=0, debug mode=0, debug saved bits=0, both saved PCs=0, trap type=0, halted=0, redirect=0, next PC=0.
- R2: Break entry. The debug return address gets the current PC, the debug saved supervisor bit gets supervisor, and the debug saved trap-enable bit gets trap enable. Supervisor is set, trap enable is cleared, trap type becomes all ones and debug mode is set. Redirect pulses with next PC = {vector base, trap type, 4'b0000}.
- R3: Program, software or external entry. Previous supervisor gets supervisor, supervisor is set, trap enable is cleared, and trap type gets the handler type of that source. Redirect pulses to {vector base, trap type, 4'b0000}. An external interrupt saves the current PC as the return address.
- R4: Program and software entries save the previous-group PC when the precise flag is 1 and the current PC when it is 0.
- R5: A program or software entry taken while trap enable is 0 is carried out in full, and halted is set on the same edge.
- R6: An external interrupt is accepted only when trap enable is 1 and its level is at or above the mask level. The all-ones level is accepted whatever the mask. A deferred request changes nothing.
- R7: A normal return (supervisor=1, trap enable=0, debug mode=0, debug field=0) redirects to the saved return address, sets trap enable and copies previous supervisor into supervisor.
- R8: A debug return (supervisor=1, trap enable=0, debug mode=1, debug field=1) redirects to the debug return address, restores supervisor and trap enable from the debug saved bits and clears debug mode.
- R9: Return checks run in this order. If supervisor=0 and trap enable=0, it halts with no redirect. If supervisor=0 and trap enable=1, it redirects to current PC+4. If supervisor=1 and trap enable=1, it halts with no redirect. If the debug field does not match debug mode, it redirects to current PC+4.
- R10: The software trap type is ((base + offset) AND 0x7f) + 0x80, computed with 32-bit arithmetic.
- R11: Priority, highest first: break, program, software, an accepted external interrupt, return, status write.
- R12: Once halted, the block ignores every request, and all outputs hold with redirect at 0 until reset.
- R13: A status write, taken only when no higher request is accepted, loads supervisor, trap enable and previous supervisor from the write inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_req_i | input | 1 | Break request |
| prog_req_i | input | 1 | Program exception request |
| prog_tt_i | input | TT_W | Handler type for the program exception |
| precise_i | input | 1 | Program/software request is precise |
| sw_req_i | input | 1 | Software trap request |
| sw_base_i | input | ADDR_W | Software trap base operand |
| sw_ofs_i | input | ADDR_W | Software trap offset operand |
| ext_req_i | input | 1 | External interrupt request |
| ext_lvl_i | input | LVL_W | External interrupt level |
| ext_tt_i | input | TT_W | Handler type for the external interrupt |
| mask_lvl_i | input | LVL_W | Current interrupt mask level |
| ret_req_i | input | 1 | Return-from-trap request |
| ret_dbg_i | input | 1 | Debug field of the return request |
| stat_wr_i | input | 1 | Status write request |
| stat_wr_sup_i | input | 1 | Supervisor value to write |
| stat_wr_en_i | input | 1 | Trap enable value to write |
| stat_wr_prev_i | input | 1 | Previous supervisor value to write |
| cur_pc_i | input | ADDR_W | Current PC |
| prev_pc_i | input | ADDR_W | PC of the previous instruction group |
| vec_hi_i | input | ADDR_W-TT_W-4 | Vector base upper bits |
| redirect_o | output | 1 | Fetch redirect pulse |
| next_pc_o | output | ADDR_W | Redirect target |
| sup_o | output | 1 | Supervisor mode |
| prev_sup_o | output | 1 | Previous supervisor mode |
| trap_en_o | output | 1 | Traps enabled |
| dbg_mode_o | output | 1 | Inside a break handler |
| dbg_sup_o | output | 1 | Supervisor bit saved on break |
| dbg_trap_en_o | output | 1 | Trap enable saved on break |
| epc_o | output | ADDR_W | Saved return address |
| dbg_epc_o | output | ADDR_W | Debug return address |
| trap_type_o | output | TT_W | Current trap type |
| halted_o | output | 1 | Core stopped (sticky) |

## Verification
The assertions check these on every cycle: that halted never clears and freezes the saved state, that every entry leaves the core in supervisor mode with traps disabled and a redirect, that break entry sets debug mode, that a masked external request is never chosen while traps are off, and that a normal return re-enables traps. Some behaviour only shows up in the bench's scenarios. This covers the exact values saved and restored through both return paths, the precise-or-current choice of return address, the software trap number arithmetic, the all-ones level bypassing the mask, and which request wins when several arrive together.

// File: rtl/trapctl_pkg.sv
package trapctl_pkg;
  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_BRK  = 3'd1,
    EV_PROG = 3'd2,
    EV_SW   = 3'd3,
    EV_EXT  = 3'd4,
    EV_RET  = 3'd5,
    EV_WR   = 3'd6
  } ev_e;
endpackage

// File: rtl/trapctl_swnum.sv
module trapctl_swnum #(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] ofs_i,
  output logic [TT_W-1:0]   num_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << (TT_W-1)) - 1);
  localparam logic [ADDR_W-1:0] BIAS     = ADDR_W'(1 << (TT_W-1));

  logic [ADDR_W-1:0] sum;
  assign sum   = base_i + ofs_i;
  // R10: fold the sum into the upper half of the type space
  assign num_o = TT_W'((sum & LOW_MASK) + BIAS);
endmodule

// File: rtl/trapctl_arb.sv
module trapctl_arb
  import trapctl_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halted_i,
  input  logic             trap_en_i,
  input  logic             brk_i,
  input  logic             prog_i,
  input  logic             sw_i,
  input  logic             ext_i,
  input  logic             ret_i,
  input  logic             wr_i,
  input  logic [LVL_W-1:0] ext_lvl_i,
  input  logic [LVL_W-1:0] mask_lvl_i,
  output ev_e              ev_o
);
  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  logic ext_ok;
  // R6: top level bypasses the mask, traps must be enabled
  assign ext_ok = ext_i && trap_en_i &&
                  ((ext_lvl_i == TOP_LVL) || (ext_lvl_i >= mask_lvl_i));

  // R11: fixed priority chain
  always_comb begin
    if (halted_i)    ev_o = EV_NONE;
    else if (brk_i)  ev_o = EV_BRK;
    else if (prog_i) ev_o = EV_PROG;
    else if (sw_i)   ev_o = EV_SW;
    else if (ext_ok) ev_o = EV_EXT;
    else if (ret_i)  ev_o = EV_RET;
    else if (wr_i)   ev_o = EV_WR;
    else             ev_o = EV_NONE;
  end

  // R6
  ext_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_i && !trap_en_i) |-> (ev_o != EV_EXT));

  // R11
  brk_first_chk: assert property (@(posedge clk) disable iff (rst)
    (brk_i && !halted_i) |-> (ev_o == EV_BRK));
endmodule

// File: rtl/trapctl_state.sv
module trapctl_state
  import trapctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ev_e                     ev_i,
  input  logic [ADDR_W-1:0]       cur_pc_i,
  input  logic [ADDR_W-1:0]       prev_pc_i,
  input  logic                    precise_i,
  input  logic [TT_W-1:0]         prog_tt_i,
  input  logic [TT_W-1:0]         sw_tt_i,
  input  logic [TT_W-1:0]         ext_tt_i,
  input  logic [ADDR_W-TT_W-5:0]  vec_hi_i,
  input  logic                    ret_dbg_i,
  input  logic                    wr_sup_i,
  input  logic                    wr_en_i,
  input  logic                    wr_prev_i,
  output logic                    redirect_o,
  output logic [ADDR_W-1:0]       next_pc_o,
  output logic                    sup_o,
  output logic                    prev_sup_o,
  output logic                    trap_en_o,
  output logic                    dbg_mode_o,
  output logic                    dbg_sup_o,
  output logic                    dbg_trap_en_o,
  output logic [ADDR_W-1:0]       epc_o,
  output logic [ADDR_W-1:0]       dbg_epc_o,
  output logic [TT_W-1:0]         trap_type_o,
  output logic                    halted_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [TT_W-1:0]   BRK_TT = '1;

  logic              sup_q, ps_q, et_q, dbg_q, bs_q, bet_q, halt_q, redir_q;
  logic [ADDR_W-1:0] epc_q, depc_q, npc_q;
  logic [TT_W-1:0]   tt_q;

  logic              sup_n, ps_n, et_n, dbg_n, bs_n, bet_n, halt_n, redir_n;
  logic [ADDR_W-1:0] epc_n, depc_n, npc_n;
  logic [TT_W-1:0]   tt_n;
  logic              entry;

  always_comb begin
    sup_n = sup_q;  ps_n = ps_q;   et_n = et_q;   dbg_n = dbg_q;
    bs_n  = bs_q;   bet_n = bet_q; halt_n = halt_q;
    epc_n = epc_q;  depc_n = depc_q; npc_n = npc_q; tt_n = tt_q;
    redir_n = 1'b0;
    entry   = 1'b0;
    case (ev_i)
      EV_BRK: begin
        bs_n = sup_q; bet_n = et_q;
        sup_n = 1'b1; et_n = 1'b0;
        depc_n = cur_pc_i;
        tt_n = BRK_TT;
        dbg_n = 1'b1;
        entry = 1'b1;
      end
      EV_PROG, EV_SW: begin
        ps_n = sup_q; sup_n = 1'b1; et_n = 1'b0;
        epc_n = precise_i ? prev_pc_i : cur_pc_i;
        tt_n = (ev_i == EV_PROG) ? prog_tt_i : sw_tt_i;
        entry = 1'b1;
        if (!et_q) halt_n = 1'b1;
      end
      EV_EXT: begin
        ps_n = sup_q; sup_n = 1'b1; et_n = 1'b0;
        epc_n = cur_pc_i;
        tt_n = ext_tt_i;
        entry = 1'b1;
      end
      EV_RET: begin
        if (!sup_q) begin
          if (!et_q) halt_n = 1'b1;
          else begin
            redir_n = 1'b1; npc_n = cur_pc_i + STEP;
          end
        end else if (et_q) begin
          halt_n = 1'b1;
        end else if (!dbg_q && !ret_dbg_i) begin
          redir_n = 1'b1; npc_n = epc_q;
          et_n = 1'b1; sup_n = ps_q;
        end else if (dbg_q && ret_dbg_i) begin
          redir_n = 1'b1; npc_n = depc_q;
          et_n = bet_q; sup_n = bs_q; dbg_n = 1'b0;
        end else begin
          redir_n = 1'b1; npc_n = cur_pc_i + STEP;
        end
      end
      EV_WR: begin
        sup_n = wr_sup_i; et_n = wr_en_i; ps_n = wr_prev_i;
      end
      default: ;
    endcase
    if (entry) begin
      redir_n = 1'b1;
      npc_n   = {vec_hi_i, tt_n, 4'b0000};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sup_q <= 1'b1; ps_q <= 1'b0; et_q <= 1'b0; dbg_q <= 1'b0;
      bs_q <= 1'b0; bet_q <= 1'b0; halt_q <= 1'b0; redir_q <= 1'b0;
      epc_q <= '0; depc_q <= '0; npc_q <= '0; tt_q <= '0;
    end else begin
      sup_q <= sup_n; ps_q <= ps_n; et_q <= et_n; dbg_q <= dbg_n;
      bs_q <= bs_n; bet_q <= bet_n; halt_q <= halt_n; redir_q <= redir_n;
      epc_q <= epc_n; depc_q <= depc_n; npc_q <= npc_n; tt_q <= tt_n;
    end
  end

  assign redirect_o    = redir_q;
  assign next_pc_o     = npc_q;
  assign sup_o         = sup_q;
  assign prev_sup_o    = ps_q;
  assign trap_en_o     = et_q;
  assign dbg_mode_o    = dbg_q;
  assign dbg_sup_o     = bs_q;
  assign dbg_trap_en_o = bet_q;
  assign epc_o         = epc_q;
  assign dbg_epc_o     = depc_q;
  assign trap_type_o   = tt_q;
  assign halted_o      = halt_q;

  // R12
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q);

  // R12
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> ($stable(epc_q) && $stable(sup_q) && !redir_q));

  // R2
  brk_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_BRK) |=> (dbg_q && sup_q && !et_q && redir_q));

  // R3
  trap_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_PROG || ev_i == EV_SW || ev_i == EV_EXT)
      |=> (sup_q && !et_q && redir_q));

  // R7
  ret_normal_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_i == EV_RET && sup_q && !et_q && !dbg_q && !ret_dbg_i)
      |=> (et_q && redir_q));
endmodule

// File: rtl/trapctl_top.sv
module trapctl_top
  import trapctl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 8,
  parameter int LVL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    brk_req_i,
  input  logic                    prog_req_i,
  input  logic [TT_W-1:0]         prog_tt_i,
  input  logic                    precise_i,
  input  logic                    sw_req_i,
  input  logic [ADDR_W-1:0]       sw_base_i,
  input  logic [ADDR_W-1:0]       sw_ofs_i,
  input  logic                    ext_req_i,
  input  logic [LVL_W-1:0]        ext_lvl_i,
  input  logic [TT_W-1:0]         ext_tt_i,
  input  logic [LVL_W-1:0]        mask_lvl_i,
  input  logic                    ret_req_i,
  input  logic                    ret_dbg_i,
  input  logic                    stat_wr_i,
  input  logic                    stat_wr_sup_i,
  input  logic                    stat_wr_en_i,
  input  logic                    stat_wr_prev_i,
  input  logic [ADDR_W-1:0]       cur_pc_i,
  input  logic [ADDR_W-1:0]       prev_pc_i,
  input  logic [ADDR_W-TT_W-5:0]  vec_hi_i,
  output logic                    redirect_o,
  output logic [ADDR_W-1:0]       next_pc_o,
  output logic                    sup_o,
  output logic                    prev_sup_o,
  output logic                    trap_en_o,
  output logic                    dbg_mode_o,
  output logic                    dbg_sup_o,
  output logic                    dbg_trap_en_o,
  output logic [ADDR_W-1:0]       epc_o,
  output logic [ADDR_W-1:0]       dbg_epc_o,
  output logic [TT_W-1:0]         trap_type_o,
  output logic                    halted_o
);
  ev_e             ev;
  logic [TT_W-1:0] sw_tt;

  trapctl_swnum #(.ADDR_W(ADDR_W), .TT_W(TT_W)) u_swnum (
    .base_i (sw_base_i),
    .ofs_i  (sw_ofs_i),
    .num_o  (sw_tt)
  );

  trapctl_arb #(.LVL_W(LVL_W)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .halted_i   (halted_o),
    .trap_en_i  (trap_en_o),
    .brk_i      (brk_req_i),
    .prog_i     (prog_req_i),
    .sw_i       (sw_req_i),
    .ext_i      (ext_req_i),
    .ret_i      (ret_req_i),
    .wr_i       (stat_wr_i),
    .ext_lvl_i  (ext_lvl_i),
    .mask_lvl_i (mask_lvl_i),
    .ev_o       (ev)
  );

  trapctl_state #(.ADDR_W(ADDR_W), .TT_W(TT_W)) u_state (
    .clk           (clk),
    .rst           (rst),
    .ev_i          (ev),
    .cur_pc_i      (cur_pc_i),
    .prev_pc_i     (prev_pc_i),
    .precise_i     (precise_i),
    .prog_tt_i     (prog_tt_i),
    .sw_tt_i       (sw_tt),
    .ext_tt_i      (ext_tt_i),
    .vec_hi_i      (vec_hi_i),
    .ret_dbg_i     (ret_dbg_i),
    .wr_sup_i      (stat_wr_sup_i),
    .wr_en_i       (stat_wr_en_i),
    .wr_prev_i     (stat_wr_prev_i),
    .redirect_o    (redirect_o),
    .next_pc_o     (next_pc_o),
    .sup_o         (sup_o),
    .prev_sup_o    (prev_sup_o),
    .trap_en_o     (trap_en_o),
    .dbg_mode_o    (dbg_mode_o),
    .dbg_sup_o     (dbg_sup_o),
    .dbg_trap_en_o (dbg_trap_en_o),
    .epc_o         (epc_o),
    .dbg_epc_o     (dbg_epc_o),
    .trap_type_o   (trap_type_o),
    .halted_o      (halted_o)
  );
endmodule

// File: tb/trapctl_top_bench.sv
module trapctl_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic brk, prog, precise, sw, ext, ret, rdbg, wr, wsup, wen, wprev;
  logic [7:0]  prog_tt, ext_tt;
  logic [31:0] sw_base, sw_ofs, cur_pc, prev_pc;
  logic [3:0]  ext_lvl, mask_lvl;
  logic [19:0] vec_hi;

  logic        redirect, sup, psup, ten, dbg, dsup, dten, halted;
  logic [31:0] npc, epc, depc;
  logic [7:0]  tt;

  trapctl_top u_trapctl_top (
    .clk(clk), .rst(rst), .brk_req_i(brk), .prog_req_i(prog), .prog_tt_i(prog_tt),
    .precise_i(precise), .sw_req_i(sw), .sw_base_i(sw_base), .sw_ofs_i(sw_ofs),
    .ext_req_i(ext), .ext_lvl_i(ext_lvl), .ext_tt_i(ext_tt), .mask_lvl_i(mask_lvl),
    .ret_req_i(ret), .ret_dbg_i(rdbg), .stat_wr_i(wr), .stat_wr_sup_i(wsup),
    .stat_wr_en_i(wen), .stat_wr_prev_i(wprev), .cur_pc_i(cur_pc), .prev_pc_i(prev_pc),
    .vec_hi_i(vec_hi), .redirect_o(redirect), .next_pc_o(npc), .sup_o(sup),
    .prev_sup_o(psup), .trap_en_o(ten), .dbg_mode_o(dbg), .dbg_sup_o(dsup),
    .dbg_trap_en_o(dten), .epc_o(epc), .dbg_epc_o(depc), .trap_type_o(tt),
    .halted_o(halted)
  );

  int checks = 0;
  int errors = 0;

  // reference state
  logic        m_sup, m_ps, m_et, m_dbg, m_bs, m_bet, m_halt, m_redir;
  logic [31:0] m_epc, m_depc, m_npc;
  logic [7:0]  m_tt;

  function automatic logic [7:0] swnum(input logic [31:0] b, input logic [31:0] o);
    logic [31:0] v;
    v = ((b + o) & 32'h7f) + 32'h80;
    return v[7:0];
  endfunction

  function automatic logic [31:0] vaddr(input logic [7:0] t);
    return {vec_hi, t, 4'h0};
  endfunction

  task automatic m_reset();
    m_sup = 1; m_ps = 0; m_et = 0; m_dbg = 0; m_bs = 0; m_bet = 0;
    m_halt = 0; m_redir = 0; m_epc = 0; m_depc = 0; m_npc = 0; m_tt = 0;
  endtask

  task automatic clear_in();
    brk = 0; prog = 0; precise = 0; sw = 0; ext = 0; ret = 0; rdbg = 0;
    wr = 0; wsup = 0; wen = 0; wprev = 0;
  endtask

  // compute the expected next state from the current inputs
  task automatic m_step(output string tag);
    m_redir = 0;
    if (m_halt) tag = "R12";
    else if (brk) begin
      tag = "R2";
      m_bs = m_sup; m_bet = m_et; m_sup = 1; m_et = 0; m_depc = cur_pc;
      m_tt = 8'hff; m_dbg = 1; m_redir = 1; m_npc = vaddr(8'hff);
    end else if (prog || sw) begin
      tag = prog ? "R3" : "R10";
      if (!m_et) begin m_halt = 1; tag = "R5"; end
      m_ps = m_sup; m_sup = 1; m_et = 0;
      m_epc = precise ? prev_pc : cur_pc;
      m_tt = prog ? prog_tt : swnum(sw_base, sw_ofs);
      m_redir = 1; m_npc = vaddr(m_tt);
    end else if (ext && m_et && (ext_lvl == 4'hf || ext_lvl >= mask_lvl)) begin
      tag = "R6";
      m_ps = m_sup; m_sup = 1; m_et = 0; m_epc = cur_pc; m_tt = ext_tt;
      m_redir = 1; m_npc = vaddr(ext_tt);
    end else if (ret) begin
      tag = "R9";
      if (!m_sup && !m_et) m_halt = 1;
      else if (!m_sup) begin m_redir = 1; m_npc = cur_pc + 4; end
      else if (m_et) m_halt = 1;
      else if (!m_dbg && !rdbg) begin
        tag = "R7"; m_redir = 1; m_npc = m_epc; m_et = 1; m_sup = m_ps;
      end else if (m_dbg && rdbg) begin
        tag = "R8"; m_redir = 1; m_npc = m_depc; m_et = m_bet; m_sup = m_bs; m_dbg = 0;
      end else begin m_redir = 1; m_npc = cur_pc + 4; end
    end else if (wr) begin
      tag = "R13"; m_sup = wsup; m_et = wen; m_ps = wprev;
    end else tag = "R6";
  endtask

  task automatic compare(input string tag);
    checks++;
    if ({redirect, sup, psup, ten, dbg, dsup, dten, halted, npc, epc, depc, tt} !==
        {m_redir, m_sup, m_ps, m_et, m_dbg, m_bs, m_bet, m_halt, m_npc, m_epc, m_depc, m_tt}) begin
      errors++;
      $display("FAIL %s: got redir=%b sup=%b ps=%b et=%b dbg=%b bs=%b bet=%b halt=%b npc=%h epc=%h depc=%h tt=%h exp redir=%b sup=%b ps=%b et=%b dbg=%b bs=%b bet=%b halt=%b npc=%h epc=%h depc=%h tt=%h",
        tag, redirect, sup, psup, ten, dbg, dsup, dten, halted, npc, epc, depc, tt,
        m_redir, m_sup, m_ps, m_et, m_dbg, m_bs, m_bet, m_halt, m_npc, m_epc, m_depc, m_tt);
    end
  endtask

  // apply current inputs for one cycle (called at a falling edge) and check
  task automatic cyc(input string force_tag);
    string tag;
    m_step(tag);
    if (force_tag != "") tag = force_tag;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    clear_in();
  endtask

  task automatic do_reset();
    clear_in();
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    m_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    clear_in();
    prog_tt = 8'h12; ext_tt = 8'h31; sw_base = 0; sw_ofs = 0;
    cur_pc = 32'h0000_1000; prev_pc = 32'h0000_0ff8;
    ext_lvl = 0; mask_lvl = 0; vec_hi = 20'hABCDE;
    do_reset();
    compare("R1");

    // R6: external deferred while traps off
    ext = 1; ext_lvl = 4'hf; cyc("R6");
    // R7: normal return from reset state -> traps on, user mode
    ret = 1; cyc("R7");
    // R6: below mask deferred
    ext = 1; ext_lvl = 4'd3; mask_lvl = 4'd5; cyc("R6");
    // R6: top level bypasses mask
    ext = 1; ext_lvl = 4'hf; mask_lvl = 4'hf; cur_pc = 32'h2000; cyc("R6");
    ret = 1; cyc("R7");
    // R6: at-mask accepted
    ext = 1; ext_lvl = 4'd5; mask_lvl = 4'd5; cyc("R6");
    ret = 1; cyc("R7");
    // R4: precise and imprecise
    prog = 1; precise = 1; cur_pc = 32'h3000; prev_pc = 32'h2ff0; cyc("R4");
    ret = 1; cyc("R7");
    prog = 1; precise = 0; cyc("R4");
    ret = 1; cyc("R7");
    // R2 then mismatched debug return (R9) then debug return (R8)
    brk = 1; cur_pc = 32'h4444; cyc("R2");
    ret = 1; rdbg = 0; cur_pc = 32'h5000; cyc("R9");
    ret = 1; rdbg = 1; cyc("R8");
    // R11: all at once -> break
    brk = 1; prog = 1; sw = 1; ext = 1; ret = 1; cyc("R11");
    ret = 1; rdbg = 1; cyc("R8");
    // R11: program beats external and software
    prog = 1; sw = 1; ext = 1; ext_lvl = 4'hf; cyc("R11");
    ret = 1; cyc("R7");
    // R10: software trap numbers
    sw = 1; sw_base = 32'h7f; sw_ofs = 32'h1; cyc("R10");
    ret = 1; cyc("R7");
    sw = 1; sw_base = 32'hffff_ffff; sw_ofs = 32'h82; cyc("R10");
    ret = 1; cyc("R7");
    // R13 + R9: supervisor with traps on then return halts
    wr = 1; wsup = 1; wen = 1; wprev = 1; cyc("R13");
    ret = 1; cyc("R9");
    // R12: halted ignores break
    brk = 1; cyc("R12");
    // R9: user mode traps off return halts
    do_reset();
    wr = 1; wsup = 0; wen = 0; cyc("R13");
    ret = 1; cyc("R9");
    // R9: user mode traps on return advances
    do_reset();
    wr = 1; wsup = 0; wen = 1; cyc("R13");
    ret = 1; cur_pc = 32'h6000; cyc("R9");
    // R5: program taken with traps off halts after entry
    do_reset();
    prog = 1; cyc("R5");
    ext = 1; ret = 1; cyc("R12");

    // random mix
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if (m_halt) do_reset();
      brk  = ($urandom % 23) == 0;
      prog = ($urandom % 11) == 0;
      sw   = ($urandom % 11) == 0;
      ext  = ($urandom % 4) == 0;
      ret  = ($urandom % 3) == 0;
      rdbg = $urandom % 2;
      wr   = ($urandom % 9) == 0;
      wsup = $urandom % 2; wen = $urandom % 2; wprev = $urandom % 2;
      precise = $urandom % 2;
      prog_tt = $urandom; ext_tt = $urandom;
      sw_base = $urandom; sw_ofs = $urandom;
      ext_lvl = $urandom; mask_lvl = $urandom;
      cur_pc = $urandom & 32'hffff_fffc; prev_pc = $urandom & 32'hffff_fffc;
      cyc("");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule